// File: doc/BRIEF.md
# Code/Data Memory Strobe Router

This block sits between a processor's memory strobes and the memories behind them. Each cycle it takes a 16-bit address and three request strobes: code fetch, data load and data store. It decides whether the access goes to the 16 KB internal code/data RAM at the bottom of the address space, to a 512-byte internal scratchpad, or to an external memory bus.

Code fetches and data loads of the low 16 KB share one internal RAM. Any access that lands in internal memory keeps the external strobes inactive, so a full 64 KB external part can be wired to the bus without an address decoder of its own. A mode input `ea_ext` moves the low 16 KB of code space onto the external bus. In that mode the internal RAM stays reachable, but only as data memory.

All outputs are registered together with the address, so the external strobes change only on a clock edge and carry no decode glitches. When more than one strobe is active in the same cycle, one request wins by fixed priority and an error flag is raised.

Top module: `mem_strobe_router`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take their idle values on that edge: `iram_sel_o`=0, `int_we_o`=0, `spad_sel_o`=0, `ext_rd_n_o`=1, `ext_wr_n_o`=1, `multi_err_o`=0 and `mem_addr_o`=0.
- R2: A data load from 0x0000–0x3FFF sets `iram_sel_o`=1, keeps both external strobes high and leaves `int_we_o`=0. This holds in both modes.
- R3: With `ea_ext`=0, a code fetch from 0x0000–0x3FFF sets `iram_sel_o`=1 and keeps both external strobes high.
- R4: With `ea_ext`=1, a code fetch from 0x0000–0x3FFF drives `ext_rd_n_o`=0 and leaves `iram_sel_o`=0.
- R5: A code fetch from 0x4000 or above drives `ext_rd_n_o`=0 in either mode. This includes the scratchpad window.
- R6: A data load or store in 0xE000–0xE1FF sets `spad_sel_o`=1 with both external strobes high. At 0xDFFF and at 0xE200 the access goes to the external bus.
- R7: A data store to the internal RAM or the scratchpad sets `int_we_o`=1 together with that region's select, and keeps `ext_wr_n_o`=1.
- R8: A data store outside both internal regions drives `ext_wr_n_o`=0 and keeps `int_we_o`=0 and `ext_rd_n_o`=1.
- R9: Every output is registered. The outputs reflect the inputs sampled on the previous clock edge, and `mem_addr_o` equals the address sampled on that edge.
- R10: When two or more strobes are active at once, store wins over load, and load wins over fetch. `multi_err_o` is 1 in the following cycle. With zero or one strobe active, `multi_err_o` is 0.
- R11: With no strobe active, all selects and `int_we_o` are 0 and both external strobes are 1.
- R12: At most one of `iram_sel_o`, `spad_sel_o`, active `ext_rd_n_o` and active `ext_wr_n_o` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ea_ext | input | 1 | 1: the low 16 KB of code space is external |
| addr_i | input | 16 | Access address |
| fetch_i | input | 1 | Code fetch strobe, active high |
| load_i | input | 1 | Data load strobe, active high |
| store_i | input | 1 | Data store strobe, active high |
| mem_addr_o | output | 16 | Registered address |
| iram_sel_o | output | 1 | Internal 16 KB RAM select |
| int_we_o | output | 1 | Write enable for the selected internal region |
| spad_sel_o | output | 1 | Scratchpad select |
| ext_rd_n_o | output | 1 | External read strobe, active low |
| ext_wr_n_o | output | 1 | External write strobe, active low |
| multi_err_o | output | 1 | More than one strobe was active in the previous cycle |

## Verification
Five properties are checked on every cycle. At most one target is active at a time. The write enable never appears without an internal select. The error flag follows any overlap of strobes. A load that hits internal RAM gets the RAM one cycle later. The registered address tracks the input.

Some behaviours are shown only by the bench's directed scenarios:
- the mode-dependent routing of fetches in the low 16 KB;
- the exact edges of the scratchpad window at 0xDFFF, 0xE000, 0xE1FF and 0xE200;
- which request wins in each combination of overlapping strobes;
- the idle values after a reset applied in the middle of traffic.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_LOAD  = 2'd2,
        ACC_STORE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic iram_sel;
        logic int_we;
        logic spad_sel;
        logic ext_rd_n;
        logic ext_wr_n;
        logic multi_err;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{
        iram_sel:  1'b0,
        int_we:    1'b0,
        spad_sel:  1'b0,
        ext_rd_n:  1'b1,
        ext_wr_n:  1'b1,
        multi_err: 1'b0
    };

    function automatic logic overlap3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/msr_arbiter.sv
module msr_arbiter
    import msr_pkg::*;
(
    input  logic      fetch,
    input  logic      load,
    input  logic      store,
    output acc_kind_e kind,
    output logic      clash
);

    always_comb begin
        if (store)      kind = ACC_STORE;
        else if (load)  kind = ACC_LOAD;
        else if (fetch) kind = ACC_FETCH;
        else            kind = ACC_IDLE;
    end

    assign clash = overlap3(fetch, load, store);

endmodule

// File: rtl/msr_region.sv
module msr_region #(
    parameter int ADDR_W     = 16,
    parameter int IRAM_BYTES = 16384,
    parameter int SPAD_BASE  = 'hE000,
    parameter int SPAD_BYTES = 512
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_iram,
    output logic              in_spad
);

    localparam int            SPAD_END_I = SPAD_BASE + SPAD_BYTES;
    localparam logic [ADDR_W:0] IRAM_LIM = IRAM_BYTES[ADDR_W:0];
    localparam logic [ADDR_W:0] SPAD_LO  = SPAD_BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] SPAD_HI  = SPAD_END_I[ADDR_W:0];

    logic [ADDR_W:0] addr_x;

    assign addr_x  = {1'b0, addr};
    assign in_iram = (addr_x < IRAM_LIM);
    assign in_spad = (addr_x >= SPAD_LO) && (addr_x < SPAD_HI);

endmodule

// File: rtl/msr_steer.sv
module msr_steer
    import msr_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      clash,
    input  logic      in_iram,
    input  logic      in_spad,
    input  logic      ea_ext,
    output strobe_t   nxt
);

    always_comb begin
        nxt           = STROBE_IDLE;
        nxt.multi_err = clash;
        unique case (kind)
            ACC_FETCH: begin
                if (in_iram && !ea_ext) nxt.iram_sel = 1'b1;
                else                    nxt.ext_rd_n = 1'b0;
            end
            ACC_LOAD: begin
                if (in_iram)      nxt.iram_sel = 1'b1;
                else if (in_spad) nxt.spad_sel = 1'b1;
                else              nxt.ext_rd_n = 1'b0;
            end
            ACC_STORE: begin
                if (in_iram) begin
                    nxt.iram_sel = 1'b1;
                    nxt.int_we   = 1'b1;
                end else if (in_spad) begin
                    nxt.spad_sel = 1'b1;
                    nxt.int_we   = 1'b1;
                end else begin
                    nxt.ext_wr_n = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msr_outreg.sv
module msr_outreg
    import msr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           d_strb,
    input  logic [ADDR_W-1:0] d_addr,
    output strobe_t           q_strb,
    output logic [ADDR_W-1:0] q_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_strb <= STROBE_IDLE;
            q_addr <= '0;
        end else begin
            q_strb <= d_strb;
            q_addr <= d_addr;
        end
    end

endmodule

// File: rtl/mem_strobe_router.sv
module mem_strobe_router
    import msr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int IRAM_BYTES = 16384,
    parameter int SPAD_BASE  = 'hE000,
    parameter int SPAD_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_ext,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              fetch_i,
    input  logic              load_i,
    input  logic              store_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              iram_sel_o,
    output logic              int_we_o,
    output logic              spad_sel_o,
    output logic              ext_rd_n_o,
    output logic              ext_wr_n_o,
    output logic              multi_err_o
);

    acc_kind_e kind;
    logic      clash;
    logic      hit_iram;
    logic      hit_spad;
    strobe_t   nxt_strb;
    strobe_t   cur_strb;

    msr_arbiter arb_i (
        .fetch (fetch_i),
        .load  (load_i),
        .store (store_i),
        .kind  (kind),
        .clash (clash)
    );

    msr_region #(
        .ADDR_W     (ADDR_W),
        .IRAM_BYTES (IRAM_BYTES),
        .SPAD_BASE  (SPAD_BASE),
        .SPAD_BYTES (SPAD_BYTES)
    ) rgn_i (
        .addr    (addr_i),
        .in_iram (hit_iram),
        .in_spad (hit_spad)
    );

    msr_steer steer_i (
        .kind    (kind),
        .clash   (clash),
        .in_iram (hit_iram),
        .in_spad (hit_spad),
        .ea_ext  (ea_ext),
        .nxt     (nxt_strb)
    );

    msr_outreg #(.ADDR_W(ADDR_W)) oreg_i (
        .clk    (clk),
        .rst    (rst),
        .d_strb (nxt_strb),
        .d_addr (addr_i),
        .q_strb (cur_strb),
        .q_addr (mem_addr_o)
    );

    assign iram_sel_o  = cur_strb.iram_sel;
    assign int_we_o    = cur_strb.int_we;
    assign spad_sel_o  = cur_strb.spad_sel;
    assign ext_rd_n_o  = cur_strb.ext_rd_n;
    assign ext_wr_n_o  = cur_strb.ext_wr_n;
    assign multi_err_o = cur_strb.multi_err;

    // R12
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({iram_sel_o, spad_sel_o, ~ext_rd_n_o, ~ext_wr_n_o}));

    // R7
    we_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        int_we_o |-> (iram_sel_o || spad_sel_o));

    // R10
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({fetch_i, load_i, store_i}) > 1) |=> multi_err_o);

    // R2
    load_iram_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !store_i && hit_iram) |=> (iram_sel_o && ext_rd_n_o && ext_wr_n_o));

    // R9
    addr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mem_addr_o == $past(addr_i)));

endmodule

// File: tb/mem_strobe_router_tb_top.sv
module mem_strobe_router_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_ext = 1'b0;
    logic [15:0] addr_i = '0;
    logic        fetch_i = 1'b0;
    logic        load_i = 1'b0;
    logic        store_i = 1'b0;
    logic [15:0] mem_addr_o;
    logic        iram_sel_o, int_we_o, spad_sel_o, ext_rd_n_o, ext_wr_n_o, multi_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mem_strobe_router dut_i (
        .clk         (clk),
        .rst         (rst),
        .ea_ext      (ea_ext),
        .addr_i      (addr_i),
        .fetch_i     (fetch_i),
        .load_i      (load_i),
        .store_i     (store_i),
        .mem_addr_o  (mem_addr_o),
        .iram_sel_o  (iram_sel_o),
        .int_we_o    (int_we_o),
        .spad_sel_o  (spad_sel_o),
        .ext_rd_n_o  (ext_rd_n_o),
        .ext_wr_n_o  (ext_wr_n_o),
        .multi_err_o (multi_err_o)
    );

    // order: iram_sel, int_we, spad_sel, ext_rd_n, ext_wr_n, multi_err
    task automatic compare(input logic [5:0] exp, input logic [15:0] exp_addr, input string req);
        logic [5:0] act;
        act = {iram_sel_o, int_we_o, spad_sel_o, ext_rd_n_o, ext_wr_n_o, multi_err_o};
        n_checks++;
        if (act !== exp || mem_addr_o !== exp_addr) begin
            n_fail++;
            $display("FAIL %s: strobes=%b addr=%h expected strobes=%b addr=%h",
                     req, act, mem_addr_o, exp, exp_addr);
        end
    endtask

    task automatic drive_check(input logic [15:0] a, input logic f, input logic l,
                               input logic s, input logic e, input logic [5:0] exp,
                               input string req);
        @(negedge clk);
        addr_i = a; fetch_i = f; load_i = l; store_i = s; ea_ext = e;
        @(negedge clk);
        compare(exp, a, req);
    endtask

    localparam logic [5:0] IDLE   = 6'b000110;
    localparam logic [5:0] IRD    = 6'b100110;
    localparam logic [5:0] IWR    = 6'b110110;
    localparam logic [5:0] SRD    = 6'b001110;
    localparam logic [5:0] SWR    = 6'b011110;
    localparam logic [5:0] XRD    = 6'b000010;
    localparam logic [5:0] XWR    = 6'b000100;

    task automatic t_reset();
        // R1: idle values while reset is applied
        repeat (2) @(negedge clk);
        compare(IDLE, 16'h0000, "R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_load_iram();
        drive_check(16'h0000, 0, 1, 0, 0, IRD, "R2");
        drive_check(16'h3FFF, 0, 1, 0, 1, IRD, "R2");
        drive_check(16'h4000, 0, 1, 0, 0, XRD, "R2");
    endtask

    task automatic t_fetch_ea0();
        drive_check(16'h0123, 1, 0, 0, 0, IRD, "R3");
        drive_check(16'h3FFF, 1, 0, 0, 0, IRD, "R3");
    endtask

    task automatic t_fetch_ea1();
        drive_check(16'h0000, 1, 0, 0, 1, XRD, "R4");
        drive_check(16'h2ABC, 1, 0, 0, 1, XRD, "R4");
        drive_check(16'h2ABC, 0, 1, 0, 1, IRD, "R4");
    endtask

    task automatic t_fetch_high();
        drive_check(16'h4000, 1, 0, 0, 0, XRD, "R5");
        drive_check(16'hE100, 1, 0, 0, 0, XRD, "R5");
        drive_check(16'hFFFF, 1, 0, 0, 1, XRD, "R5");
    endtask

    task automatic t_spad();
        drive_check(16'hDFFF, 0, 1, 0, 0, XRD, "R6");
        drive_check(16'hE000, 0, 1, 0, 0, SRD, "R6");
        drive_check(16'hE1FF, 0, 1, 0, 1, SRD, "R6");
        drive_check(16'hE200, 0, 1, 0, 0, XRD, "R6");
        drive_check(16'hE1FF, 0, 0, 1, 0, SWR, "R6");
    endtask

    task automatic t_store_int();
        drive_check(16'h1000, 0, 0, 1, 0, IWR, "R7");
        drive_check(16'h3FFF, 0, 0, 1, 1, IWR, "R7");
        drive_check(16'hE000, 0, 0, 1, 1, SWR, "R7");
    endtask

    task automatic t_store_ext();
        drive_check(16'h4000, 0, 0, 1, 0, XWR, "R8");
        drive_check(16'hE200, 0, 0, 1, 0, XWR, "R8");
        drive_check(16'hDFFF, 0, 0, 1, 1, XWR, "R8");
    endtask

    task automatic t_registered();
        // R9: output still shows the earlier access until the next edge
        @(negedge clk);
        addr_i = 16'h0042; fetch_i = 0; load_i = 0; store_i = 1; ea_ext = 0;
        @(negedge clk);
        addr_i = 16'h8000; store_i = 0; load_i = 1;
        #1;
        compare(IWR, 16'h0042, "R9");
        @(negedge clk);
        compare(XRD, 16'h8000, "R9");
    endtask

    task automatic t_priority();
        drive_check(16'h1000, 0, 1, 1, 0, 6'b110111, "R10");
        drive_check(16'h5000, 1, 1, 0, 0, 6'b000011, "R10");
        drive_check(16'h2000, 1, 1, 0, 1, 6'b100111, "R10");
        drive_check(16'hE100, 1, 1, 1, 0, 6'b011111, "R10");
        drive_check(16'h9000, 1, 0, 1, 0, 6'b000101, "R10");
        drive_check(16'h9000, 1, 0, 0, 0, XRD,        "R10");
    endtask

    task automatic t_idle();
        drive_check(16'h1000, 0, 0, 0, 0, IDLE, "R11");
        drive_check(16'hE000, 0, 0, 0, 1, IDLE, "R11");
    endtask

    task automatic t_midreset();
        // R1: reset during active traffic returns to idle
        @(negedge clk);
        addr_i = 16'h4444; store_i = 1; load_i = 1;
        rst = 1'b1;
        @(negedge clk);
        compare(IDLE, 16'h0000, "R1");
        rst = 1'b0; store_i = 0; load_i = 0;
        @(negedge clk);
    endtask

    task automatic t_exclusive();
        // R12: a mix of routes, each with a single target
        drive_check(16'h0010, 0, 0, 1, 0, IWR, "R12");
        drive_check(16'hC000, 1, 0, 0, 0, XRD, "R12");
        drive_check(16'hE010, 0, 1, 0, 0, SRD, "R12");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_load_iram();
        t_fetch_ea0();
        t_fetch_ea1();
        t_fetch_high();
        t_spad();
        t_store_int();
        t_store_ext();
        t_registered();
        t_priority();
        t_idle();
        t_midreset();
        t_exclusive();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule